// File: doc/BRIEF.md
# Translation Cache with Hardware Page-Table Walker

This block turns virtual addresses into physical addresses for 4 KiB pages. It keeps a small fully associative set of recently used page-table entries. A requester presents one virtual address while `busy` is low. The block answers with a one-cycle `resp_valid` pulse that carries either the physical address or a fault flag.

When no stored entry matches, an internal walker fetches the entry from a single-level page table in physical memory. The table sits at the base address given on `ptbr` and is indexed by virtual page number. If the page is present, the walker installs the entry and retries the lookup. If it is absent, the walker reports a fault. Each stored entry tracks whether its referenced or dirty flags have changed since it was loaded. Such an entry is written back to its slot in the table before that slot is reused.

The memory side uses a simple request/acknowledge handshake, and every transfer is one full page-table entry. A `flush` pulse empties the whole cache in one cycle.

Top module: `xlat_unit`

## Requirements
- R1: The physical address is the entry's physical page number joined to the untranslated low 12 address bits. `resp_valid` is high for exactly one cycle per accepted request. A request is accepted only while `busy` is low.
- R2: When a stored entry matches, the response appears two clock edges after acceptance and no memory transfer takes place.
- R3: Any page may occupy any slot. The page number is compared against every slot at once, and at most one slot matches.
- R4: On a miss, the walker reads the entry at `ptbr + vpn*4`. Entry layout: bit 0 = present, bit 1 = referenced, bit 2 = dirty, physical page number from bit 12 upward. If the page is present, the walker installs the entry, retries the lookup and responds with the translation.
- R5: If the fetched entry has present = 0, the response has `resp_fault` = 1, nothing is installed, and the access is not completed.
- R6: The slot to fill is the lowest-numbered invalid slot. If every slot is valid, the slot is chosen by a round-robin pointer that starts at 0 and advances (wrapping) on every install.
- R7: Every access sets the entry's referenced flag, and a write also sets its dirty flag. An entry whose flags changed this way is written back (present = 1, its page number and flags) to its own table address before the new entry is read into its slot. An unchanged victim is not written.
- R8: `busy` stays high from acceptance until the response. `mem_req` is raised only while `busy` is high and is held until `mem_ack`.
- R9: `flush` invalidates all slots in one cycle. Flag changes not yet written back are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all slots |
| ptbr | input | PA_W | Physical base address of the page table |
| req_valid | input | 1 | Translation request (taken when busy is low) |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| busy | output | 1 | Request in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | PA_W | Translated physical address |
| resp_fault | output | 1 | Page not present |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write-back |
| mem_addr | output | PA_W | Page-table entry address |
| mem_wdata | output | PTE_W | Entry written back |
| mem_ack | input | 1 | Transfer done (read data valid) |
| mem_rdata | input | PTE_W | Entry read from memory |

## Verification
The bench builds the block with ENTRIES = 4 and the default 32-bit address and entry widths. With only four slots, a few accesses fill the cache, so the round-robin pointer wraps and victims are evicted early. Both changed and unchanged victims are reached, which lets the bench check the order of write-back and read. The bench also checks the flag values that land in the page table.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int OFS_W       = 12;
    localparam int PTE_PRES    = 0;
    localparam int PTE_REF     = 1;
    localparam int PTE_DIRTY   = 2;
    localparam int PTE_PPN_LSB = 12;

    typedef enum logic [1:0] {
        W_IDLE,
        W_LOOK,
        W_WB,
        W_RD
    } walk_st_t;

    typedef struct packed {
        logic dirty;
        logic refd;
        logic present;
    } pte_flags_t;

    function automatic pte_flags_t flags_of(input logic [2:0] low);
        pte_flags_t f;
        f.present = low[PTE_PRES];
        f.refd    = low[PTE_REF];
        f.dirty   = low[PTE_DIRTY];
        return f;
    endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             upd_en,
    input  logic             upd_wr,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             wb_done,
    input  logic             fill_en,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_ref,
    input  logic             fill_dirty,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    output logic [IDX_W-1:0] pick_idx,
    output logic             sel_valid,
    output logic             sel_mod,
    output logic [VPN_W-1:0] sel_vpn,
    output logic [PPN_W-1:0] sel_ppn,
    output logic             sel_ref,
    output logic             sel_dirty
);
    logic [ENTRIES-1:0] v_q, mod_q, ref_q, dty_q, match;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [IDX_W-1:0]   rr_q, hit_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = v_q[g] && (tag_q[g] == lk_vpn);
    end

    always_comb begin
        hit      = |match;
        hit_idx  = '0;
        pick_idx = rr_q;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
            if (!v_q[i])  pick_idx = IDX_W'(i);
        end
    end

    assign hit_ppn   = ppn_q[hit_idx];
    assign sel_valid = v_q[sel_idx];
    assign sel_mod   = mod_q[sel_idx];
    assign sel_vpn   = tag_q[sel_idx];
    assign sel_ppn   = ppn_q[sel_idx];
    assign sel_ref   = ref_q[sel_idx];
    assign sel_dirty = dty_q[sel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= '0;
            mod_q <= '0;
            ref_q <= '0;
            dty_q <= '0;
            rr_q  <= '0;
        end else begin
            if (upd_en) begin
                ref_q[hit_idx] <= 1'b1;
                if (upd_wr) dty_q[hit_idx] <= 1'b1;
                if (!ref_q[hit_idx] || (upd_wr && !dty_q[hit_idx]))
                    mod_q[hit_idx] <= 1'b1;
            end
            if (wb_done) mod_q[sel_idx] <= 1'b0;
            if (fill_en) begin
                v_q[sel_idx]   <= 1'b1;
                mod_q[sel_idx] <= 1'b0;
                ref_q[sel_idx] <= fill_ref;
                dty_q[sel_idx] <= fill_dirty;
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            end
            if (flush) v_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[sel_idx] <= lk_vpn;
            ppn_q[sel_idx] <= fill_ppn;
        end
    end

    AST_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R3
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush |=> (v_q == '0)); // R9
    AST_RR_RANGE: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (32'(rr_q) < ENTRIES)); // R6
endmodule

// File: rtl/xlat_walk.sv
module xlat_walk
    import xlat_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    parameter int PA_W  = 32,
    parameter int PTE_W = 32,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic             req_write,
    input  logic [PA_W-1:0]  ptbr,
    input  logic             hit,
    input  logic [PPN_W-1:0] hit_ppn,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             sel_valid,
    input  logic             sel_mod,
    input  logic [VPN_W-1:0] sel_vpn,
    input  logic [PPN_W-1:0] sel_ppn,
    input  logic             sel_ref,
    input  logic             sel_dirty,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic [VPN_W-1:0] lk_vpn,
    output logic             upd_en,
    output logic             upd_wr,
    output logic [IDX_W-1:0] sel_idx,
    output logic             wb_done,
    output logic             fill_en,
    output logic [PPN_W-1:0] fill_ppn,
    output logic             fill_ref,
    output logic             fill_dirty,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             busy
);
    localparam int PTE_SH = $clog2(PTE_W / 8);

    walk_st_t         st_q;
    logic [VPN_W-1:0] cur_vpn;
    logic [OFS_W-1:0] cur_ofs;
    logic             cur_wr;
    logic [IDX_W-1:0] vic_q;
    pte_flags_t       rd_f;
    logic [VPN_W-1:0] addr_vpn;
    logic             unused_rd;

    assign rd_f      = flags_of(mem_rdata[2:0]);
    assign unused_rd = ^mem_rdata;

    always_comb begin
        sel_idx    = (st_q == W_LOOK) ? pick_idx : vic_q;
        lk_vpn     = cur_vpn;
        upd_en     = (st_q == W_LOOK) && hit;
        upd_wr     = cur_wr;
        wb_done    = (st_q == W_WB) && mem_ack;
        fill_en    = (st_q == W_RD) && mem_ack && rd_f.present;
        fill_ppn   = mem_rdata[PTE_PPN_LSB +: PPN_W];
        fill_ref   = rd_f.refd;
        fill_dirty = rd_f.dirty;
        mem_req    = (st_q == W_WB) || (st_q == W_RD);
        mem_we     = (st_q == W_WB);
        addr_vpn   = (st_q == W_WB) ? sel_vpn : cur_vpn;
        mem_addr   = ptbr + (PA_W'(addr_vpn) << PTE_SH);
        mem_wdata  = '0;
        mem_wdata[PTE_PPN_LSB +: PPN_W] = sel_ppn;
        mem_wdata[PTE_PRES]  = 1'b1;
        mem_wdata[PTE_REF]   = sel_ref;
        mem_wdata[PTE_DIRTY] = sel_dirty;
        busy       = (st_q != W_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= W_IDLE;
            cur_vpn    <= '0;
            cur_ofs    <= '0;
            cur_wr     <= 1'b0;
            vic_q      <= '0;
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_paddr <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (st_q)
                W_IDLE: if (req_valid) begin
                    cur_vpn <= req_vpn;
                    cur_ofs <= req_ofs;
                    cur_wr  <= req_write;
                    st_q    <= W_LOOK;
                end
                W_LOOK: if (hit) begin
                    resp_valid <= 1'b1;
                    resp_fault <= 1'b0;
                    resp_paddr <= {hit_ppn, cur_ofs};
                    st_q       <= W_IDLE;
                end else begin
                    vic_q <= pick_idx;
                    st_q  <= (sel_valid && sel_mod) ? W_WB : W_RD;
                end
                W_WB: if (mem_ack) st_q <= W_RD;
                W_RD: if (mem_ack) begin
                    if (rd_f.present) begin
                        st_q <= W_LOOK;
                    end else begin
                        resp_valid <= 1'b1;
                        resp_fault <= 1'b1;
                        resp_paddr <= '0;
                        st_q       <= W_IDLE;
                    end
                end
                default: st_q <= W_IDLE;
            endcase
        end
    end

    AST_MEM_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R8
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R1
    AST_WB_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (st_q == W_WB && mem_ack) |=> (st_q == W_RD && !sel_mod)); // R7
    AST_FAULT_RESP: assert property (@(posedge clk) disable iff (rst)
        (st_q == W_RD && mem_ack && !rd_f.present) |=> (resp_valid && resp_fault && !busy)); // R5
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PTE_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [PA_W-1:0]  ptbr,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             busy,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata
);
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int IDX_W = $clog2(ENTRIES);

    logic [VPN_W-1:0] lk_vpn, sel_vpn;
    logic [PPN_W-1:0] hit_ppn, sel_ppn, fill_ppn;
    logic [IDX_W-1:0] pick_idx, sel_idx;
    logic hit, upd_en, upd_wr, wb_done, fill_en, fill_ref, fill_dirty;
    logic sel_valid, sel_mod, sel_ref, sel_dirty;

    xlat_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_cam (
        .clk(clk), .rst(rst), .flush(flush), .lk_vpn(lk_vpn),
        .upd_en(upd_en), .upd_wr(upd_wr), .sel_idx(sel_idx), .wb_done(wb_done),
        .fill_en(fill_en), .fill_ppn(fill_ppn), .fill_ref(fill_ref), .fill_dirty(fill_dirty),
        .hit(hit), .hit_ppn(hit_ppn), .pick_idx(pick_idx),
        .sel_valid(sel_valid), .sel_mod(sel_mod), .sel_vpn(sel_vpn), .sel_ppn(sel_ppn),
        .sel_ref(sel_ref), .sel_dirty(sel_dirty)
    );

    xlat_walk #(.VPN_W(VPN_W), .PPN_W(PPN_W), .PA_W(PA_W), .PTE_W(PTE_W), .IDX_W(IDX_W)) u_walk (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_vpn(req_vaddr[VA_W-1:OFS_W]), .req_ofs(req_vaddr[OFS_W-1:0]),
        .req_write(req_write), .ptbr(ptbr),
        .hit(hit), .hit_ppn(hit_ppn), .pick_idx(pick_idx),
        .sel_valid(sel_valid), .sel_mod(sel_mod), .sel_vpn(sel_vpn), .sel_ppn(sel_ppn),
        .sel_ref(sel_ref), .sel_dirty(sel_dirty),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .lk_vpn(lk_vpn), .upd_en(upd_en), .upd_wr(upd_wr), .sel_idx(sel_idx),
        .wb_done(wb_done), .fill_en(fill_en), .fill_ppn(fill_ppn),
        .fill_ref(fill_ref), .fill_dirty(fill_dirty),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .busy(busy)
    );
endmodule

// File: tb/sim_xlat_unit.sv
module sim_xlat_unit;
    localparam int ENT = 4;
    localparam logic [31:0] PTBR = 32'h0004_0000;

    logic clk = 0, rst = 1, flush = 0, req_valid = 0, req_write = 0;
    logic [31:0] req_vaddr = '0;
    logic busy, resp_valid, resp_fault, mem_req, mem_we;
    logic [31:0] resp_paddr, mem_addr, mem_wdata;
    logic mem_ack = 0;
    logic [31:0] mem_rdata = '0;

    int tests = 0, fails = 0, seq = 0;
    logic [31:0] pmem [int unsigned];
    int mv[ENT], mt[ENT], mppn[ENT], mr[ENT], md[ENT], mm[ENT];
    int rr = 0;

    always #2 clk = ~clk;

    xlat_unit #(.ENTRIES(ENT)) u0 (
        .clk(clk), .rst(rst), .flush(flush), .ptbr(PTBR),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .busy(busy), .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pte(input int ppn, input bit p, input bit r, input bit d);
        return (32'(ppn) << 12) | {29'b0, d, r, p};
    endfunction

    // memory responder and per-clock protocol check
    always @(negedge clk) begin
        if (!rst && mem_req && !busy) chk(0, "R8", "mem_req without busy", 0, 1);
        if (mem_req && !mem_ack) begin
            mem_ack = 1;
            if (mem_we) begin
                pmem[mem_addr] = mem_wdata;
                seq = seq * 10 + 2;
            end else begin
                mem_rdata = pmem.exists(mem_addr) ? pmem[mem_addr] : 32'h0;
                seq = seq * 10 + 1;
            end
        end else begin
            mem_ack = 0;
        end
    end

    task automatic access(input int vpn, input int ofs, input bit wr, input string req);
        int hi = -1, vic, eseq = 0, eppn = 0, w;
        bit efault = 0;
        logic [31:0] p;
        for (int i = 0; i < ENT; i++) if (mv[i] != 0 && mt[i] == vpn) hi = i;
        if (hi < 0) begin
            vic = rr;
            for (int i = ENT - 1; i >= 0; i--) if (mv[i] == 0) vic = i;
            if (mv[vic] != 0 && mm[vic] != 0) begin eseq = 2; mm[vic] = 0; end
            eseq = eseq * 10 + 1;
            p = pmem.exists(PTBR + 32'(vpn) * 4) ? pmem[PTBR + 32'(vpn) * 4] : 32'h0;
            if (p[0]) begin
                mv[vic] = 1; mt[vic] = vpn; mppn[vic] = int'(p[31:12]);
                mr[vic] = int'(p[1]); md[vic] = int'(p[2]); mm[vic] = 0;
                rr = (rr + 1) % ENT;
                hi = vic;
            end else efault = 1;
        end
        if (hi >= 0) begin
            if (mr[hi] == 0 || (wr && md[hi] == 0)) mm[hi] = 1;
            mr[hi] = 1;
            if (wr) md[hi] = 1;
            eppn = mppn[hi];
        end
        @(negedge clk);
        while (busy) @(negedge clk);
        seq = 0;
        req_valid = 1; req_vaddr = (32'(vpn) << 12) | 32'(ofs); req_write = wr;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1, "R8", "busy after accept", busy, 1);
        w = 0;
        while (!resp_valid && w < 200) begin @(negedge clk); w++; end
        chk(resp_valid == 1, "R1", "response seen", resp_valid, 1);
        chk(resp_fault == efault, req, "fault", resp_fault, efault);
        if (!efault)
            chk(resp_paddr == ((32'(eppn) << 12) | 32'(ofs)), req, "paddr",
                resp_paddr, (32'(eppn) << 12) | 32'(ofs));
        chk(seq == eseq, req, "memory ops (1=rd,2=wr)", seq, eseq);
        if (eseq == 0) chk(w == 1, "R2", "hit latency", w, 1);
        @(negedge clk);
        chk(resp_valid == 0, "R1", "strobe single", resp_valid, 0);
    endtask

    task automatic chk_flags(input int vpn, input bit r, input bit d, input string req);
        logic [31:0] p;
        p = pmem[PTBR + 32'(vpn) * 4];
        chk(p[2:0] == {d, r, 1'b1}, req, "written-back flags", p[2:0], {d, r, 1'b1});
    endtask

    initial begin
        for (int v = 1; v <= 8; v++) pmem[PTBR + 32'(v) * 4] = pte(v + 'h100, 1, 0, 0);
        pmem[PTBR + 32'd6 * 4] = pte('h106, 1, 1, 0);
        pmem[PTBR + 32'd9 * 4] = pte('h109, 0, 0, 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        chk(busy == 0 && resp_valid == 0 && mem_req == 0, "R8", "reset state",
            {busy, resp_valid, mem_req}, 0);
        access(1, 'h123, 0, "R4");   // miss, fill slot 0
        access(1, 'hfff, 1, "R2");   // hit, write
        access(9, 'h010, 0, "R5");   // absent page
        access(2, 'h000, 1, "R4");   // slot 1
        access(3, 'h456, 0, "R3");   // slot 2
        access(4, 'h789, 0, "R6");   // slot 3, pointer wraps
        access(5, 'h001, 0, "R7");   // evict slot 0 (vpn 1, changed)
        chk_flags(1, 1, 1, "R7");
        access(6, 'h002, 0, "R6");   // evict slot 1 (vpn 2)
        chk_flags(2, 1, 1, "R7");
        access(6, 'h003, 0, "R2");
        access(7, 'h004, 0, "R6");
        chk_flags(3, 1, 0, "R7");
        access(8, 'h005, 0, "R6");
        access(1, 'h006, 0, "R3");
        access(2, 'h007, 0, "R7");   // vpn 6 victim unchanged: no write
        chk(pmem[PTBR + 32'd6 * 4] == pte('h106, 1, 1, 0), "R7", "unchanged victim",
            pmem[PTBR + 32'd6 * 4], pte('h106, 1, 1, 0));
        @(negedge clk); flush = 1;
        @(negedge clk); flush = 0;
        for (int i = 0; i < ENT; i++) mv[i] = 0;
        access(2, 'h008, 0, "R9");   // miss after flush
        access(2, 'h009, 1, "R9");
        access(9, 'h00a, 1, "R5");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule